// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Signal Controller

This block sequences the signal lamps at a crossing where a busy highway meets a lightly used farm road. The highway keeps right of way by default. A vehicle sensor on the farm road asks for a change. The controller then takes the highway through an amber phase and gives the farm road green. The farm road keeps green only while a vehicle is present, and never longer than a fixed cap. After the farm road gives up green, the highway has to stay green for a minimum hold time before the farm road can be served again. Every change of right of way passes through an amber phase of fixed length on the road that is giving up.

The design has two parts. A data unit holds one interval counter, which restarts at every phase change and raises terminal-count flags for the amber length, the farm-green cap and the highway hold. A control unit holds the four-phase sequencing FSM. A separate decoder turns the phase register into the six lamp drives. Every phase code the register can hold, legal or not, lights exactly one lamp per road. An unused code decodes to red on both roads and returns to highway green on the next clock, with a fresh hold interval. The sensor and the reset are both synchronous inputs. The lamp outputs are decoded only from registered state.

Top module: `tlc_crossing_ctrl`

## Requirements
- R1: While reset is held, and on the first sample after it, the lamps show highway green and farm red. The hold interval counts as already expired after reset, so a vehicle seen at the first active edge moves the highway to amber at once.
- R2: While car_det is low, the highway stays green with the farm road red for as long as the input stays low.
- R3: In highway green with the hold satisfied, a high car_det at a clock edge switches the highway to amber at that edge.
- R4: Highway amber lasts exactly AMBER_TICKS cycles (default 3), with the farm road red and regardless of car_det. It is followed by farm green with highway red.
- R5: With car_det held high, farm green lasts exactly GREEN_CAP cycles (default 16) and then changes to farm amber.
- R6: If car_det is low at an edge during farm green, the farm road goes to amber at that edge.
- R7: Farm amber lasts exactly AMBER_TICKS cycles with the highway red, and is followed by highway green.
- R8: Once the farm road has given up green, highway green lasts at least HOLD_TICKS cycles (default 16) before highway amber, even with car_det held high.
- R9: Both greens are never lit together. Each road lights exactly one of its three lamps in every cycle, and an unused phase code shows red on both roads and returns to highway green on the next clock.
- R10: A synchronous reset asserted in any phase returns the lamps to highway green and farm red at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| car_det | input | 1 | Farm-road vehicle sensor, synchronous, active high |
| hwy_grn | output | 1 | Highway green lamp |
| hwy_amb | output | 1 | Highway amber lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_grn | output | 1 | Farm-road green lamp |
| farm_amb | output | 1 | Farm-road amber lamp |
| farm_red | output | 1 | Farm-road red lamp |

## Verification
The sensor is driven in four kinds of pattern, and each one separates a different limit.
- A long low run shows that the highway holds green when nothing is waiting.
- A sensor held high through a full cycle shows that the cap, rather than the sensor, ends farm green, and that the hold, rather than the sensor, delays the next highway amber.
- A sensor that drops after a few cycles of farm green tells the early release apart from the cap.
- A one-cycle pulse shows that amber runs to completion once started, even after the vehicle has gone.

Reset is then applied in the middle of farm green, which confirms that the hold interval is treated as expired afterwards.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    // Phase codes: one-hot-ish spacing leaves four unused codes for recovery checks
    typedef enum logic [2:0] {
        PH_HWY_GO     = 3'b001,
        PH_HWY_AMBER  = 3'b011,
        PH_FARM_GO    = 3'b110,
        PH_FARM_AMBER = 3'b100
    } phase_e;

    typedef struct packed {
        logic grn;
        logic amb;
        logic red;
    } lamp_t;

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
    parameter int GREEN_CAP   = 16,
    parameter int HOLD_TICKS  = 16,
    parameter int AMBER_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic amber_done,
    output logic cap_done,
    output logic hold_done
);

    localparam int LONG_A  = (GREEN_CAP > HOLD_TICKS) ? GREEN_CAP : HOLD_TICKS;
    localparam int LONGEST = (LONG_A > AMBER_TICKS) ? LONG_A : AMBER_TICKS;
    localparam int CW      = $clog2(LONGEST + 1);

    localparam logic [CW-1:0] AMBER_LAST = CW'(AMBER_TICKS - 1);
    localparam logic [CW-1:0] CAP_LAST   = CW'(GREEN_CAP - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] ticks;
    } tmr_state_t;

    tmr_state_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.ticks = '0;
        end else if (tmr_q.ticks != '1) begin
            tmr_d.ticks = tmr_q.ticks + 1'b1;
        end
    end

    // Reset value is saturated, so every interval reads as already elapsed
    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.ticks <= '1;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign amber_done = (tmr_q.ticks >= AMBER_LAST);
    assign cap_done   = (tmr_q.ticks >= CAP_LAST);
    assign hold_done  = (tmr_q.ticks >= HOLD_LAST);

    // R8
    tick_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (tmr_q.ticks >= $past(tmr_q.ticks)));

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !cap_done && !hold_done);

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car_det,
    input  logic   amber_done,
    input  logic   cap_done,
    input  logic   hold_done,
    output phase_e phase_q,
    output logic   restart
);

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.phase)
            PH_HWY_GO: begin
                if (car_det && hold_done) seq_d.phase = PH_HWY_AMBER;
            end
            PH_HWY_AMBER: begin
                if (amber_done) seq_d.phase = PH_FARM_GO;
            end
            PH_FARM_GO: begin
                if (!car_det || cap_done) seq_d.phase = PH_FARM_AMBER;
            end
            PH_FARM_AMBER: begin
                if (amber_done) seq_d.phase = PH_HWY_GO;
            end
            default: begin
                seq_d.phase = PH_HWY_GO;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.phase <= PH_HWY_GO;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_q = seq_q.phase;
    assign restart = (seq_d.phase != seq_q.phase);

    // R6
    early_release_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_FARM_GO && !car_det) |=> seq_q.phase == PH_FARM_AMBER);

    // R5
    cap_release_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_FARM_GO && cap_done) |=> seq_q.phase == PH_FARM_AMBER);

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_HWY_GO && !hold_done) |=> seq_q.phase == PH_HWY_GO);

endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
(
    input  phase_e phase,
    output lamp_t  hwy,
    output lamp_t  farm
);

    always_comb begin
        case (phase)
            PH_HWY_GO: begin
                hwy  = '{grn: 1'b1, amb: 1'b0, red: 1'b0};
                farm = '{grn: 1'b0, amb: 1'b0, red: 1'b1};
            end
            PH_HWY_AMBER: begin
                hwy  = '{grn: 1'b0, amb: 1'b1, red: 1'b0};
                farm = '{grn: 1'b0, amb: 1'b0, red: 1'b1};
            end
            PH_FARM_GO: begin
                hwy  = '{grn: 1'b0, amb: 1'b0, red: 1'b1};
                farm = '{grn: 1'b1, amb: 1'b0, red: 1'b0};
            end
            PH_FARM_AMBER: begin
                hwy  = '{grn: 1'b0, amb: 1'b0, red: 1'b1};
                farm = '{grn: 1'b0, amb: 1'b1, red: 1'b0};
            end
            default: begin
                hwy  = '{grn: 1'b0, amb: 1'b0, red: 1'b1};
                farm = '{grn: 1'b0, amb: 1'b0, red: 1'b1};
            end
        endcase
    end

endmodule

// File: rtl/tlc_crossing_ctrl.sv
module tlc_crossing_ctrl
    import tlc_pkg::*;
#(
    parameter int GREEN_CAP   = 16,
    parameter int HOLD_TICKS  = 16,
    parameter int AMBER_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic car_det,
    output logic hwy_grn,
    output logic hwy_amb,
    output logic hwy_red,
    output logic farm_grn,
    output logic farm_amb,
    output logic farm_red
);

    localparam int LONG_W = (GREEN_CAP > HOLD_TICKS) ? GREEN_CAP : HOLD_TICKS;
    localparam int CHK_W  = $clog2(LONG_W + 2);

    phase_e phase;
    logic   restart;
    logic   amber_done, cap_done, hold_done;
    lamp_t  hwy_lamp, farm_lamp;

    tlc_interval_timer #(
        .GREEN_CAP  (GREEN_CAP),
        .HOLD_TICKS (HOLD_TICKS),
        .AMBER_TICKS(AMBER_TICKS)
    ) i_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .amber_done(amber_done),
        .cap_done  (cap_done),
        .hold_done (hold_done)
    );

    tlc_sequencer i_seq (
        .clk       (clk),
        .rst       (rst),
        .car_det   (car_det),
        .amber_done(amber_done),
        .cap_done  (cap_done),
        .hold_done (hold_done),
        .phase_q   (phase),
        .restart   (restart)
    );

    tlc_lamp_decode i_decode (
        .phase(phase),
        .hwy  (hwy_lamp),
        .farm (farm_lamp)
    );

    assign hwy_grn  = hwy_lamp.grn;
    assign hwy_amb  = hwy_lamp.amb;
    assign hwy_red  = hwy_lamp.red;
    assign farm_grn = farm_lamp.grn;
    assign farm_amb = farm_lamp.amb;
    assign farm_red = farm_lamp.red;

    // Checker-only run counters observed at the lamp outputs
    logic [CHK_W-1:0] farm_run_q, hold_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            farm_run_q <= '0;
            hold_run_q <= '1;
        end else begin
            farm_run_q <= farm_grn ? ((farm_run_q != '1) ? farm_run_q + 1'b1 : farm_run_q) : '0;
            if (farm_amb)
                hold_run_q <= '0;
            else if (hwy_grn && hold_run_q != '1)
                hold_run_q <= hold_run_q + 1'b1;
        end
    end

    // R9
    no_dual_green_chk: assert property (@(posedge clk) disable iff (rst)
        !(hwy_grn && farm_grn));

    // R9
    one_lamp_per_road_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones({hwy_grn, hwy_amb, hwy_red}) == 1) &&
        ($countones({farm_grn, farm_amb, farm_red}) == 1));

    // R5
    farm_cap_chk: assert property (@(posedge clk) disable iff (rst)
        farm_grn |-> (farm_run_q < CHK_W'(GREEN_CAP)));

    // R8
    hold_min_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(hwy_amb) && !$past(rst)) |-> (hold_run_q >= CHK_W'(HOLD_TICKS)));

    // R4
    amber_to_farm_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(hwy_amb) && !$past(rst)) |-> farm_grn);

    // R7
    amber_to_hwy_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(farm_amb) && !$past(rst)) |-> hwy_grn);

endmodule

// File: tb/test_tlc_crossing_ctrl.sv
`timescale 1ns/1ps
module test_tlc_crossing_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_det = 1'b0;
    logic hwy_grn, hwy_amb, hwy_red, farm_grn, farm_amb, farm_red;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    tlc_crossing_ctrl i_tlc_crossing_ctrl (
        .clk     (clk),
        .rst     (rst),
        .car_det (car_det),
        .hwy_grn (hwy_grn),
        .hwy_amb (hwy_amb),
        .hwy_red (hwy_red),
        .farm_grn(farm_grn),
        .farm_amb(farm_amb),
        .farm_red(farm_red)
    );

    // Lamp vector order: {hwy_grn, hwy_amb, hwy_red, farm_grn, farm_amb, farm_red}
    localparam logic [5:0] HG = 6'b100_001;
    localparam logic [5:0] HA = 6'b010_001;
    localparam logic [5:0] FG = 6'b001_100;
    localparam logic [5:0] FA = 6'b001_010;

    // Entry: {car, cycles[5:0], requirement number[3:0], expected lamps[5:0]}
    localparam int NVEC = 16;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 6'd5,  4'd2, HG},  // R2 idle highway
        {1'b1, 6'd1,  4'd3, HA},  // R3 / R1 hold expired after reset
        {1'b1, 6'd2,  4'd4, HA},  // R4 amber length
        {1'b1, 6'd16, 4'd4, FG},  // R4 then farm green
        {1'b1, 6'd3,  4'd5, FA},  // R5 cap reached
        {1'b1, 6'd16, 4'd8, HG},  // R8 hold with car high
        {1'b1, 6'd3,  4'd4, HA},
        {1'b1, 6'd4,  4'd4, FG},
        {1'b0, 6'd1,  4'd6, FA},  // R6 early release
        {1'b0, 6'd2,  4'd7, FA},  // R7 farm amber length
        {1'b1, 6'd16, 4'd8, HG},  // R8 hold after short farm green
        {1'b1, 6'd1,  4'd3, HA},
        {1'b0, 6'd2,  4'd4, HA},  // R4 amber completes after car drops
        {1'b0, 6'd1,  4'd4, FG},
        {1'b0, 6'd3,  4'd6, FA},
        {1'b0, 6'd6,  4'd2, HG}
    };

    function automatic logic [5:0] lamps_now();
        return {hwy_grn, hwy_amb, hwy_red, farm_grn, farm_amb, farm_red};
    endfunction

    task automatic check(input logic [5:0] exp, input string tag);
        logic [5:0] act = lamps_now();
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: lamps=%b expected=%b at %0t", tag, act, exp, $time);
        end
        // R9: exclusivity and one lamp per road at every sample
        n_checks++;
        if ((hwy_grn && farm_grn) || ($countones(act[5:3]) != 1) || ($countones(act[2:0]) != 1)) begin
            n_fails++;
            $display("FAIL R9: lamps=%b expected one lamp per road, no dual green", act);
        end
    endtask

    // Called at a negedge: drive, cross one active edge, sample at next negedge
    task automatic step(input logic c, input logic r, input logic [5:0] exp, input string tag);
        car_det = c;
        rst     = r;
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        car_det = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(HG, "R1 reset state");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < int'(VEC[i][15:10]); k++) begin
                step(VEC[i][16], 1'b0, VEC[i][5:0], $sformatf("R%0d vec%0d cyc%0d", VEC[i][9:6], i, k));
            end
        end

        // R8: highway is 6 cycles into its hold; 10 more must stay green
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, HG, "R8 hold tail");
        step(1'b1, 1'b0, HA, "R3 hold just met");
        step(1'b1, 1'b0, HA, "R4 amber");
        step(1'b1, 1'b0, HA, "R4 amber");
        step(1'b1, 1'b0, FG, "R4 farm green");
        step(1'b1, 1'b0, FG, "R5 farm green");

        // R10: reset in the middle of farm green
        step(1'b1, 1'b1, HG, "R10 reset from farm green");
        // R1: hold reads as expired straight after reset
        step(1'b1, 1'b0, HA, "R1 no hold after reset");
        step(1'b0, 1'b1, HG, "R10 reset from highway amber");
        step(1'b0, 1'b0, HG, "R2 idle after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule